// File: doc/BRIEF.md
# Spectral-Line Symbol Timing Recovery

This block derives a symbol clock from the baseband output of a binary FSK demodulator. Each accepted sample is reduced to its sign and drives a first-order smoother with a corner near 3/8 of the symbol rate. The smoothed wave is squared, or full-wave rectified when a parameter selects that cheaper variant. This nonlinear step creates a discrete spectral line at the symbol rate. A second-order resonator tuned to that rate isolates the line as a clean sinusoid.

Each upward zero crossing of that sinusoid pulls a free-running sub-symbol counter one step toward a fixed phase. The counter then marks the centre of each symbol with a one-period strobe, and the sign of the input at that instant is latched as the recovered bit. A lock flag reports when successive crossings agree with the counter. An alternating 1010 preamble is the intended acquisition pattern. With the default parameters there are 16 samples per symbol, so 19.2 kHz sampling gives 1200 baud.

Top module: `bit_clk_recover`

## Requirements
- R1: On each enabled sample the limiter output is +2^(LP_W-2) if the input is non-negative and -2^(LP_W-2) if it is negative. With d the limiter output minus the smoother state y, the state updates as y <= y + (d>>>3) + (d>>>6), arithmetic shifts.
- R2: The rectifier registers (y*y)>>>(LP_W-2) of the smoother state when RECT is RECT_SQUARE. It registers |y| when RECT is RECT_ABS.
- R3: The resonator input is u = (r[n] - r[n-2])>>>4, where r is the rectifier register. The resonator updates as v <= sat(u + (29668*v1)>>>14 - (15736*v2)>>>14), with v1 and v2 its two previous outputs, saturated to a signed RES_W-bit range.
- R4: All state, including strobe_o, bit_o and lock_o, changes only on clock edges where sample_en_i is high. Input values presented while sample_en_i is low are ignored.
- R5: A positive-going crossing (previous output negative, current output non-negative) is seen on the next enabled sample. The 4-bit counter normally advances by 1 per enabled sample. On a crossing, with the phase error taken as (counter - TARGET_PH) mod 16 in the range -8..7, the counter holds when the error is positive, advances by 2 when it is negative, and advances by 1 when it is zero.
- R6: strobe_o is high for exactly one enable period following an enabled sample at which the counter equals 8. At that same sample, bit_o takes 1 if sample_i is non-negative and 0 if it is negative. Otherwise bit_o holds its value.
- R7: lock_o rises at the crossing that completes 8 consecutive crossings with a phase error within ±1. A crossing outside that window restarts the run.
- R8: After 512 consecutive enabled samples (32 symbols) without an in-window crossing, lock_o clears and the run count restarts.
- R9: Asserting rst_ni low clears the smoother, rectifier, resonator, counter, strobe, bit and lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_en_i | input | 1 | Qualifies one baseband sample |
| sample_i | input | IN_W | Signed demodulated baseband sample |
| strobe_o | output | 1 | High for one enable period at mid-symbol |
| bit_o | output | 1 | Recovered data bit |
| lock_o | output | 1 | Timing loop locked |

## Verification
The bench targets the floor behaviour of negative arithmetic shifts in the smoother and resonator. A design that rounded toward zero drifts by a count, and its crossings and strobes move away from the reference within a few symbols. Wrap-around of the phase error at ±8 is exercised because the strobe phase sits opposite the target. Getting the sign wrong there makes the counter hold when it should jump, and the strobe cadence then breaks. A stretch of constant input must drop lock after exactly 32 symbols. Sparse sample enables with changing inputs in between show whether anything leaks through while sample_en_i is low. A second instance in absolute-value mode checks the rectifier selection.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  typedef enum logic {
    RECT_SQUARE = 1'b0,
    RECT_ABS    = 1'b1
  } rect_e;
endpackage

// File: rtl/bcr_prefilter.sv
module bcr_prefilter import bcr_pkg::*; #(
  parameter int    IN_W = 12,
  parameter int    LP_W = 16,
  parameter rect_e RECT = RECT_SQUARE
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic signed [IN_W-1:0] sample_i,
  output logic                   sliced_o,
  output logic signed [LP_W-1:0] rect_o
);
  localparam int AMP      = 1 << (LP_W - 2);
  localparam int SQ_SHIFT = LP_W - 2;
  localparam int PW       = 2 * LP_W;

  logic                   neg;
  logic signed [LP_W:0]   lim, diff, step, y_ext;
  logic signed [LP_W-1:0] y_q, rect_d, rect_q;

  assign neg      = (sample_i < 0);
  assign sliced_o = ~neg;

  always_comb begin
    lim   = neg ? -(LP_W+1)'(AMP) : (LP_W+1)'(AMP);
    y_ext = (LP_W+1)'(y_q);
    diff  = lim - y_ext;
    // alpha ~ 1/8 + 1/64
    step  = (diff >>> 3) + (diff >>> 6);
  end

  generate
    if (RECT == RECT_SQUARE) begin : g_square
      logic signed [PW-1:0] prod;
      always_comb begin
        prod   = PW'(y_q) * PW'(y_q);
        rect_d = LP_W'(prod >>> SQ_SHIFT);
      end
    end else begin : g_abs
      always_comb rect_d = y_q[LP_W-1] ? -y_q : y_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q    <= '0;
      rect_q <= '0;
    end else if (en_i) begin
      y_q    <= LP_W'(y_ext + step);
      rect_q <= rect_d;
    end
  end

  assign rect_o = rect_q;
endmodule

// File: rtl/bcr_resonator.sv
module bcr_resonator #(
  parameter int IN_W       = 16,
  parameter int RES_W      = 24,
  parameter int COEF_W     = 16,
  parameter int COEF_FRAC  = 14,
  parameter int A1         = 29668,
  parameter int A2         = 15736,
  parameter int DIFF_SHIFT = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic signed [IN_W-1:0] x_i,
  output logic                   xing_o
);
  localparam int ACC_W = RES_W + COEF_W + 2;
  localparam longint MAXV = (longint'(1) <<< (RES_W - 1)) - 1;
  localparam longint MINV = -(longint'(1) <<< (RES_W - 1));
  localparam logic signed [ACC_W-1:0] MAX_A = ACC_W'(MAXV);
  localparam logic signed [ACC_W-1:0] MIN_A = ACC_W'(MINV);
  localparam logic signed [COEF_W-1:0] A1_C = COEF_W'(A1);
  localparam logic signed [COEF_W-1:0] A2_C = COEF_W'(A2);

  logic signed [IN_W-1:0]  x1_q, x2_q;
  logic signed [IN_W:0]    dx;
  logic signed [RES_W-1:0] v1_q, v2_q, v_d;
  logic signed [ACC_W-1:0] u, p1, p2, acc;

  always_comb begin
    // zeros at DC and Nyquist strip the rectifier's mean
    dx  = (IN_W+1)'(x_i) - (IN_W+1)'(x2_q);
    u   = ACC_W'(dx >>> DIFF_SHIFT);
    p1  = ACC_W'(v1_q) * ACC_W'(A1_C);
    p2  = ACC_W'(v2_q) * ACC_W'(A2_C);
    acc = u + (p1 >>> COEF_FRAC) - (p2 >>> COEF_FRAC);
    if (acc > MAX_A)      v_d = RES_W'(MAXV);
    else if (acc < MIN_A) v_d = RES_W'(MINV);
    else                  v_d = RES_W'(acc);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x1_q <= '0;
      x2_q <= '0;
      v1_q <= '0;
      v2_q <= '0;
    end else if (en_i) begin
      x1_q <= x_i;
      x2_q <= x1_q;
      v1_q <= v_d;
      v2_q <= v1_q;
    end
  end

  assign xing_o = v2_q[RES_W-1] & ~v1_q[RES_W-1];
endmodule

// File: rtl/bcr_timing.sv
module bcr_timing #(
  parameter int SPB_W     = 4,
  parameter int TARGET_PH = 0,
  parameter int STROBE_PH = 8,
  parameter int LOCK_N    = 8,
  parameter int LOSS_SYM  = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic xing_i,
  input  logic bit_i,
  output logic strobe_o,
  output logic bit_o,
  output logic lock_o
);
  localparam int SPB      = 1 << SPB_W;
  localparam int LOSS_LIM = LOSS_SYM * SPB;
  localparam int MISS_W   = $clog2(LOSS_LIM + 1);
  localparam int GOOD_W   = $clog2(LOCK_N + 1);

  logic [SPB_W-1:0]        cnt_q, cnt_d;
  logic signed [SPB_W-1:0] err;
  logic [GOOD_W-1:0]       good_q;
  logic [MISS_W-1:0]       miss_q;
  logic                    good, strobe_hit, expire;
  logic                    strobe_q, bit_q, lock_q;

  always_comb begin
    err        = $signed(cnt_q - SPB_W'(TARGET_PH));
    good       = xing_i && (err >= -1) && (err <= 1);
    strobe_hit = (cnt_q == SPB_W'(STROBE_PH));
    expire     = !good && (miss_q == MISS_W'(LOSS_LIM - 1));
    cnt_d      = cnt_q + SPB_W'(1);
    if (xing_i) begin
      if (err > 0)      cnt_d = cnt_q;
      else if (err < 0) cnt_d = cnt_q + SPB_W'(2);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      strobe_q <= 1'b0;
      bit_q    <= 1'b0;
      good_q   <= '0;
      miss_q   <= '0;
      lock_q   <= 1'b0;
    end else if (en_i) begin
      cnt_q    <= cnt_d;
      strobe_q <= strobe_hit;
      if (strobe_hit) bit_q <= bit_i;
      if (good) begin
        if (good_q != GOOD_W'(LOCK_N)) good_q <= good_q + GOOD_W'(1);
        if (good_q >= GOOD_W'(LOCK_N - 1)) lock_q <= 1'b1;
        miss_q <= '0;
      end else begin
        if (xing_i || expire) good_q <= '0;
        if (expire) lock_q <= 1'b0;
        if (miss_q != MISS_W'(LOSS_LIM)) miss_q <= miss_q + MISS_W'(1);
      end
    end
  end

  assign strobe_o = strobe_q;
  assign bit_o    = bit_q;
  assign lock_o   = lock_q;
endmodule

// File: rtl/bit_clk_recover.sv
module bit_clk_recover import bcr_pkg::*; #(
  parameter int    IN_W       = 12,
  parameter int    LP_W       = 16,
  parameter int    RES_W      = 24,
  parameter int    COEF_W     = 16,
  parameter int    COEF_FRAC  = 14,
  parameter int    RES_A1     = 29668,
  parameter int    RES_A2     = 15736,
  parameter int    DIFF_SHIFT = 4,
  parameter rect_e RECT       = RECT_SQUARE,
  parameter int    SPB_W      = 4,
  parameter int    TARGET_PH  = 0,
  parameter int    STROBE_PH  = 8,
  parameter int    LOCK_N     = 8,
  parameter int    LOSS_SYM   = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sample_en_i,
  input  logic signed [IN_W-1:0] sample_i,
  output logic                   strobe_o,
  output logic                   bit_o,
  output logic                   lock_o
);
  logic                   sliced_w, xing_w;
  logic signed [LP_W-1:0] rect_w;

  bcr_prefilter #(.IN_W(IN_W), .LP_W(LP_W), .RECT(RECT)) u_pre (
    .clk_i, .rst_ni, .en_i(sample_en_i), .sample_i,
    .sliced_o(sliced_w), .rect_o(rect_w)
  );

  bcr_resonator #(
    .IN_W(LP_W), .RES_W(RES_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC),
    .A1(RES_A1), .A2(RES_A2), .DIFF_SHIFT(DIFF_SHIFT)
  ) u_res (
    .clk_i, .rst_ni, .en_i(sample_en_i), .x_i(rect_w), .xing_o(xing_w)
  );

  bcr_timing #(
    .SPB_W(SPB_W), .TARGET_PH(TARGET_PH), .STROBE_PH(STROBE_PH),
    .LOCK_N(LOCK_N), .LOSS_SYM(LOSS_SYM)
  ) u_tim (
    .clk_i, .rst_ni, .en_i(sample_en_i), .xing_i(xing_w), .bit_i(sliced_w),
    .strobe_o, .bit_o, .lock_o
  );
endmodule

// File: rtl/bcr_checker.sv
module bcr_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic sample_en_i,
  input logic xing_i,
  input logic strobe_o,
  input logic bit_o,
  input logic lock_o
);
  assert_hold_when_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sample_en_i) |-> $stable({strobe_o, bit_o, lock_o}));

  assert_strobe_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && sample_en_i) |=> !strobe_o);

  assert_bit_on_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bit_o) |-> strobe_o);

  assert_lock_needs_crossing_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(xing_i && sample_en_i));

  assert_lock_drop_on_sample_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> $past(sample_en_i));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R9: assert (!strobe_o && !bit_o && !lock_o);
    end
  end
endmodule

bind bit_clk_recover bcr_checker chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .sample_en_i(sample_en_i), .xing_i(xing_w),
  .strobe_o(strobe_o), .bit_o(bit_o), .lock_o(lock_o)
);

// File: tb/bit_clk_recover_tb_top.sv
`timescale 1ns/1ps
module bit_clk_recover_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sample_en_i = 1'b0;
  logic signed [11:0] sample_i = '0;
  logic st_w[2], bt_w[2], lk_w[2];
  int checks = 0;
  int errors = 0;
  bit run_cmp = 1'b0;

  always #4 clk_i = ~clk_i;

  bit_clk_recover dut_i (
    .clk_i, .rst_ni, .sample_en_i, .sample_i,
    .strobe_o(st_w[0]), .bit_o(bt_w[0]), .lock_o(lk_w[0])
  );

  bit_clk_recover #(.RECT(bcr_pkg::RECT_ABS)) dut_abs_i (
    .clk_i, .rst_ni, .sample_en_i, .sample_i,
    .strobe_o(st_w[1]), .bit_o(bt_w[1]), .lock_o(lk_w[1])
  );

  // reference model, one state set per rectifier mode
  longint y_m[2], q0_m[2], q1_m[2], q2_m[2], v1_m[2], v2_m[2];
  int     cnt_m[2], gc_m[2], miss_m[2];
  bit     st_m[2], bt_m[2], lk_m[2];

  always @(posedge clk_i or negedge rst_ni) begin : model
    longint s, h, d, u, acc;
    int e;
    bit xing, good, hit;
    for (int m = 0; m < 2; m++) begin
      if (!rst_ni) begin
        y_m[m] = 0; q0_m[m] = 0; q1_m[m] = 0; q2_m[m] = 0;
        v1_m[m] = 0; v2_m[m] = 0; cnt_m[m] = 0; gc_m[m] = 0;
        miss_m[m] = 0; st_m[m] = 0; bt_m[m] = 0; lk_m[m] = 0;
      end else if (sample_en_i) begin
        s = longint'(sample_i);
        // R1 limiter and smoother
        h = (s < 0) ? -16384 : 16384;
        d = h - y_m[m];
        // R3 resonator, uses pre-update history
        u = (q0_m[m] - q2_m[m]) >>> 4;
        acc = u + ((29668 * v1_m[m]) >>> 14) - ((15736 * v2_m[m]) >>> 14);
        if (acc > 8388607) acc = 8388607;
        if (acc < -8388608) acc = -8388608;
        xing = (v2_m[m] < 0) && (v1_m[m] >= 0);
        q2_m[m] = q1_m[m];
        q1_m[m] = q0_m[m];
        // R2 rectifier selection
        q0_m[m] = (m == 0) ? ((y_m[m] * y_m[m]) >>> 14) : ((y_m[m] < 0) ? -y_m[m] : y_m[m]);
        y_m[m] = y_m[m] + (d >>> 3) + (d >>> 6);
        v2_m[m] = v1_m[m];
        v1_m[m] = acc;
        // R5 phase error mod 16 in -8..7
        e = cnt_m[m] % 16;
        if (e > 7) e = e - 16;
        hit = (cnt_m[m] == 8);
        st_m[m] = hit;
        if (hit) bt_m[m] = (s >= 0);
        if (xing && e > 0)      cnt_m[m] = cnt_m[m];
        else if (xing && e < 0) cnt_m[m] = (cnt_m[m] + 2) % 16;
        else                    cnt_m[m] = (cnt_m[m] + 1) % 16;
        good = xing && (e >= -1) && (e <= 1);
        if (good) begin
          if (gc_m[m] >= 7) lk_m[m] = 1;
          if (gc_m[m] < 8) gc_m[m]++;
          miss_m[m] = 0;
        end else begin
          if (xing) gc_m[m] = 0;
          if (miss_m[m] == 511) begin
            gc_m[m] = 0;
            lk_m[m] = 0;
          end
          if (miss_m[m] < 512) miss_m[m]++;
        end
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (run_cmp) begin
      check("R1 R3 R4 R5 R6 strobe square", st_w[0], st_m[0]);
      check("R2 R4 R5 R6 strobe abs", st_w[1], st_m[1]);
      check("R6 bit square", bt_w[0], bt_m[0]);
      check("R2 R6 bit abs", bt_w[1], bt_m[1]);
      check("R7 R8 lock square", lk_w[0], lk_m[0]);
      check("R2 R7 R8 lock abs", lk_w[1], lk_m[1]);
    end
  end

  // kind: 0 alternating, 1 random, 2 constant positive
  task automatic send(input int nbits, input int kind, input int en_per, input int skew);
    for (int i = 0; i < nbits; i++) begin
      int b = (kind == 0) ? (i & 1) : (kind == 1) ? int'($urandom & 1) : 1;
      for (int k = 0; k < 16 + ((i == 0) ? skew : 0); k++) begin
        for (int c = 0; c < en_per; c++) begin
          int amp = 500 + int'($urandom % 1200);
          int v = b ? amp : -amp;
          if (kind != 2 && ($urandom % 29) == 0) v = -v / 3;
          @(posedge clk_i); #1;
          sample_en_i = (c == 0);
          sample_i = (c == 0) ? 12'(v) : 12'($urandom);  // R4 junk while idle
        end
      end
    end
  endtask

  task automatic reset_check();
    @(posedge clk_i); #1;
    rst_ni = 1'b0;
    @(negedge clk_i);
    for (int m = 0; m < 2; m++) begin
      check("R9 strobe reset", st_w[m], 1'b0);
      check("R9 bit reset", bt_w[m], 1'b0);
      check("R9 lock reset", lk_w[m], 1'b0);
    end
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
  endtask

  initial begin : watchdog
    #1_400_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk_i);
    reset_check();
    run_cmp = 1'b1;
    send(64, 0, 1, 0);     // preamble acquisition
    send(96, 1, 1, 0);     // data
    send(40, 2, 1, 0);     // no transitions, R8 loss of lock
    send(48, 0, 3, 5);     // sparse enables, shifted preamble, R4
    send(40, 1, 2, 0);
    run_cmp = 1'b0;
    reset_check();         // R9 mid-run
    run_cmp = 1'b1;
    send(24, 0, 1, 7);
    send(16, 1, 1, 0);
    @(posedge clk_i); #1;
    sample_en_i = 1'b0;
    repeat (4) @(posedge clk_i);
    run_cmp = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule